// File: doc/BRIEF.md
# Serial Test Access Port Controller

This block is the serial test port of a chip-level test infrastructure. A sixteen-state controller is clocked by the test clock and steered only by the mode-select input. It moves a serial path between the test data input and output. On that path it places either a 4-bit instruction register or the data register that the current instruction selects. The data registers are a 1-bit bypass stage, a 32-bit identification register and one external boundary register.

The external boundary register lives outside this block. The controller gives it a serial input and takes back its serial output. It also gives it capture, shift and update strobes, a select flag and an external-test flag. Capture and shift act on the rising test clock edge. The update action, a new instruction and every change of the serial output happen on the falling edge. The serial output is enabled only while a shift state is active. A synchronous active-low reset, or five rising edges with mode-select high, returns the controller to its reset state and makes BYPASS the active instruction.

Top module: `scan_port_ctrl`

## Requirements
- R1: The controller has sixteen states: reset, idle, and, for each of the data and instruction branches, select, capture, shift, exit-1, pause, exit-2 and update. It moves between them on the rising edge of `tck`, and only `tms` picks the next state. A low `rst_n` at a rising edge puts it in the reset state.
- R2: Five consecutive rising edges with `tms` high reach the reset state from any state. While the controller is in the reset state the active instruction is BYPASS (`instr_o` = 4'b1111).
- R3: The instruction register is 4 bits wide. In instruction-capture it loads 4'b0001, and it shifts least significant bit first, with `tdi` entering at the top. The shifted value becomes the active instruction on the falling edge of `tck` in instruction-update, and not on the rising edge before it.
- R4: The codes are EXTEST 4'b0000, IDCODE 4'b0010, SAMPLE/PRELOAD 4'b0101 and BYPASS 4'b1111. Every other code becomes BYPASS, and `instr_o` then reads 4'b1111.
- R5: Under BYPASS the data path is a single stage that captures 0 in data-capture. Through it, `tdo` repeats each `tdi` bit one shift later.
- R6: Under IDCODE the data path is 32 bits. It captures `ID_VALUE` with bit 0 forced to 1 and shifts it out least significant bit first.
- R7: EXTEST and SAMPLE/PRELOAD both set `bsr_sel` and put `bsr_so` on the data path. `bsr_extest` is high only under EXTEST. `bsr_si` always carries `tdi`.
- R8: With `bsr_sel` high, `bsr_capture`, `bsr_shift` and `bsr_update` are high exactly in data-capture, data-shift and data-update. They stay low under any other instruction.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only in the data-shift and instruction-shift states, and `tdo` is 0 whenever `tdo_oe` is low.
- R10: Passing through exit-1, pause and exit-2 halts a shift without changing the register contents. The bits that follow continue the same stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial test data out, changes on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo, high only while shifting |
| instr_o | output | 4 | Active decoded instruction |
| bsr_sel | output | 1 | Boundary register selected |
| bsr_extest | output | 1 | Boundary cells in external-test mode |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_shift | output | 1 | Boundary shift strobe |
| bsr_update | output | 1 | Boundary update strobe, acted on at the falling edge |
| bsr_si | output | 1 | Serial input to the boundary register |

## Verification
A wrong controller state shows at `tdo_oe` on the next falling edge. A random walk of `tms` is therefore checked, step by step, against a state model in the bench. A wrong capture value or a wrong shift order in any register shows within one scan, as a misplaced bit in the serial stream read back at `tdo`. A wrong instruction decode shows on `instr_o` and on the boundary strobes right after instruction-update. It also changes the length of the data path, which the next data scan exposes.

// File: rtl/scan_pkg.sv
// scan_pkg: shared types and constants of the test access port.
// Assumes a 4-bit instruction register and a 32-bit identification path.
package scan_pkg;
    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET  = 4'h0,
        ST_IDLE   = 4'h1,
        ST_SEL_DR = 4'h2,
        ST_CAP_DR = 4'h3,
        ST_SHF_DR = 4'h4,
        ST_EX1_DR = 4'h5,
        ST_PAU_DR = 4'h6,
        ST_EX2_DR = 4'h7,
        ST_UPD_DR = 4'h8,
        ST_SEL_IR = 4'h9,
        ST_CAP_IR = 4'hA,
        ST_SHF_IR = 4'hB,
        ST_EX1_IR = 4'hC,
        ST_PAU_IR = 4'hD,
        ST_EX2_IR = 4'hE,
        ST_UPD_IR = 4'hF
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0010;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0101;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;
endpackage

// File: rtl/scan_fsm.sv
// scan_fsm: sixteen-state controller stepped on the rising test clock edge.
// Assumes rst_n is sampled synchronously on the rising edge.
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t state_q;
    tap_state_t state_d;

    // Next-state selection steered only by tms.
    always_comb begin
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    assign state = state_q;

    // Checker support: consecutive tms-high edges since reset, saturating at 5.
    logic [2:0] ones_q;
    always_ff @(posedge tck) begin
        if (!rst_n || !tms)       ones_q <= 3'd0;
        else if (ones_q != 3'd5)  ones_q <= ones_q + 3'd1;
    end

    a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_q == 3'd5) |-> (state_q == ST_RESET));

    a_r1_capture_enters_shift: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q == ST_CAP_DR && !tms) |=> (state_q == ST_SHF_DR));

    a_r1_update_leaves_to_idle: assert property (@(posedge tck) disable iff (!rst_n)
        ((state_q == ST_UPD_DR || state_q == ST_UPD_IR) && !tms) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/scan_ir.sv
// scan_ir: instruction shift stage (rising edge) and active instruction (falling edge).
// Assumes the controller state comes from scan_fsm. Unknown codes become BYPASS.
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_t      state,
    output logic            ir_so,
    output logic [IR_W-1:0] instr
);
    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] instr_q;
    logic [IR_W-1:0] decoded;

    // Capture the fixed pattern, or shift towards bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                 sr_q <= IR_CAPTURE_PAT;
        else if (state == ST_CAP_IR) sr_q <= IR_CAPTURE_PAT;
        else if (state == ST_SHF_IR) sr_q <= {tdi, sr_q[IR_W-1:1]};
    end

    // Map unsupported codes onto BYPASS.
    always_comb begin
        unique case (sr_q)
            OP_EXTEST, OP_IDCODE, OP_SAMPLE: decoded = sr_q;
            default:                         decoded = OP_BYPASS;
        endcase
    end

    // Active instruction changes on the falling edge, in reset or update.
    always_ff @(negedge tck) begin
        if (!rst_n || state == ST_RESET) instr_q <= OP_BYPASS;
        else if (state == ST_UPD_IR)     instr_q <= decoded;
    end

    assign ir_so = sr_q[0];
    assign instr = instr_q;

    a_r2_reset_gives_bypass: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |-> (instr_q == OP_BYPASS));

    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (sr_q == IR_CAPTURE_PAT));

    a_r4_known_codes_only: assert property (@(posedge tck) disable iff (!rst_n)
        (instr_q == OP_EXTEST || instr_q == OP_IDCODE ||
         instr_q == OP_SAMPLE || instr_q == OP_BYPASS));
endmodule

// File: rtl/scan_dregs.sv
// scan_dregs: internal data registers, the 1-bit bypass and the identification register.
// Assumes the active instruction comes from scan_ir. Bit 0 of the ID is forced to 1.
module scan_dregs
    import scan_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h5A3C_9E61
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_t      state,
    input  logic [IR_W-1:0] instr,
    output logic            byp_so,
    output logic            id_so
);
    localparam logic [ID_W-1:0] ID_FIXED = {ID_VALUE[ID_W-1:1], 1'b1};

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            id_sel;
    logic            byp_sel;

    assign id_sel  = (instr == OP_IDCODE);
    assign byp_sel = (instr == OP_BYPASS);

    // Single bypass stage: capture 0, then pass tdi through.
    always_ff @(posedge tck) begin
        if (!rst_n)                              byp_q <= 1'b0;
        else if (byp_sel && state == ST_CAP_DR)  byp_q <= 1'b0;
        else if (byp_sel && state == ST_SHF_DR)  byp_q <= tdi;
    end

    // Identification register: capture the ID, shift towards bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                             id_q <= ID_FIXED;
        else if (id_sel && state == ST_CAP_DR)  id_q <= ID_FIXED;
        else if (id_sel && state == ST_SHF_DR)  id_q <= {tdi, id_q[ID_W-1:1]};
    end

    assign byp_so = byp_q;
    assign id_so  = id_q[0];

    a_r5_bypass_captures_zero: assert property (@(posedge tck) disable iff (!rst_n)
        (byp_sel && state == ST_CAP_DR) |=> (byp_q == 1'b0));

    a_r6_id_lsb_one: assert property (@(posedge tck) disable iff (!rst_n)
        (id_sel && state == ST_CAP_DR) |=> (id_q[0] == 1'b1));

    a_r10_pause_holds: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_PAU_DR) |=> ($stable(id_q) && $stable(byp_q)));
endmodule

// File: rtl/scan_port_ctrl.sv
// scan_port_ctrl: top of the test access port. Ties the controller, the
// instruction register and the data registers together, selects the serial
// path and drives tdo on the falling edge. Assumes one external boundary register.
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h5A3C_9E61
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic            bsr_so,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [IR_W-1:0] instr_o,
    output logic            bsr_sel,
    output logic            bsr_extest,
    output logic            bsr_capture,
    output logic            bsr_shift,
    output logic            bsr_update,
    output logic            bsr_si
);
    tap_state_t      state;
    logic            ir_so;
    logic            byp_so;
    logic            id_so;
    logic [IR_W-1:0] instr;
    logic            dr_so;
    logic            tdo_q;
    logic            oe_q;

    scan_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    scan_ir u_ir (
        .tck   (tck),
        .rst_n (rst_n),
        .tdi   (tdi),
        .state (state),
        .ir_so (ir_so),
        .instr (instr)
    );

    scan_dregs #(.ID_VALUE(ID_VALUE)) u_dregs (
        .tck    (tck),
        .rst_n  (rst_n),
        .tdi    (tdi),
        .state  (state),
        .instr  (instr),
        .byp_so (byp_so),
        .id_so  (id_so)
    );

    // Boundary selection and strobes for the external register.
    assign bsr_sel     = (instr == OP_EXTEST) || (instr == OP_SAMPLE);
    assign bsr_extest  = (instr == OP_EXTEST);
    assign bsr_capture = bsr_sel && (state == ST_CAP_DR);
    assign bsr_shift   = bsr_sel && (state == ST_SHF_DR);
    assign bsr_update  = bsr_sel && (state == ST_UPD_DR);
    assign bsr_si      = tdi;

    // Data path multiplexer chosen by the active instruction.
    always_comb begin
        if (bsr_sel)                  dr_so = bsr_so;
        else if (instr == OP_IDCODE)  dr_so = id_so;
        else                          dr_so = byp_so;
    end

    // Serial output and its enable, updated on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (state == ST_SHF_IR) begin
            tdo_q <= ir_so;
            oe_q  <= 1'b1;
        end else if (state == ST_SHF_DR) begin
            tdo_q <= dr_so;
            oe_q  <= 1'b1;
        end else begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end
    end

    assign tdo     = tdo_q;
    assign tdo_oe  = oe_q;
    assign instr_o = instr;

    a_r8_one_strobe: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update}));

    a_r9_quiet_when_off: assert property (@(posedge tck) disable iff (!rst_n)
        !oe_q |-> !tdo_q);

    a_r9_stable_over_rise: assert property (@(negedge tck) disable iff (!rst_n)
        (state == ST_IDLE) |=> !oe_q);
endmodule

// File: tb/tb_scan_port_ctrl.sv
module tb_scan_port_ctrl;
    import scan_pkg::*;

    localparam logic [31:0] ID_PARAM = 32'h5A3C_9E60;
    localparam logic [31:0] ID_EXP   = 32'h5A3C_9E61;
    localparam logic [7:0]  EXT_CAP  = 8'hC5;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b1;
    logic       bsr_so;
    logic       tdo, tdo_oe, bsr_sel, bsr_extest, bsr_capture, bsr_shift, bsr_update, bsr_si;
    logic [3:0] instr_o;

    int checks = 0;
    int errors = 0;
    int upd_cnt = 0;
    logic [7:0] ext_q = 8'h00;
    tap_state_t mst = ST_RESET;

    always #5 tck = ~tck;

    scan_port_ctrl #(.ID_VALUE(ID_PARAM)) dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .instr_o(instr_o), .bsr_sel(bsr_sel),
        .bsr_extest(bsr_extest), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .bsr_si(bsr_si)
    );

    // External boundary register model.
    always @(posedge tck) begin
        if (bsr_capture)    ext_q <= EXT_CAP;
        else if (bsr_shift) ext_q <= {bsr_si, ext_q[7:1]};
    end
    assign bsr_so = ext_q[0];

    always @(negedge tck) if (rst_n && bsr_update) upd_cnt++;

    function automatic tap_state_t nxt(tap_state_t s, logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic logic [3:0] decode(logic [3:0] c);
        if (c == 4'b0000 || c == 4'b0010 || c == 4'b0101) return c;
        return 4'b1111;
    endfunction

    // Expected bit i read at tdo during a data scan of `din` under instruction `op`.
    function automatic logic exp_dr(logic [3:0] op, logic [63:0] din, int i);
        if (op == 4'b0010) return (i < 32) ? ID_EXP[i] : din[i-32];
        if (op == 4'b0000 || op == 4'b0101) return (i < 8) ? EXT_CAP[i] : din[i-8];
        return (i == 0) ? 1'b0 : din[i-1];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(logic m, logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        mst = nxt(mst, m);
        @(negedge tck);
        #1;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // Instruction scan from idle; returns captured bits; checks the falling-edge update (R3).
    task automatic ir_scan(logic [3:0] code, output logic [3:0] cap);
        logic [3:0] old;
        old = instr_o;
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            step(i == 3, code[i]);
        end
        tms = 1'b1;
        @(posedge tck);
        mst = nxt(mst, 1'b1);
        #1;
        chk("R3 instruction held before falling edge", {60'd0, instr_o}, {60'd0, old});
        @(negedge tck);
        #1;
        chk("R3 instruction applied at falling edge", {60'd0, instr_o}, {60'd0, decode(code)});
        step(1'b0, 1'b0);
    endtask

    // Data scan of n bits from idle, with an optional pause after bit pause_at.
    task automatic dr_scan(int n, logic [63:0] din, int pause_at, output logic [63:0] dout);
        dout = '0;
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (i == pause_at && i != n - 1) begin
                step(1'b1, din[i]); step(1'b0, 1'b0); step(1'b0, 1'b0);
                chk("R9 R10 output off in pause", {63'd0, tdo_oe}, 64'd0);
                step(1'b1, 1'b0); step(1'b0, 1'b0);
            end else begin
                step(i == n - 1, din[i]);
            end
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0]  cap;
        logic [63:0] din, dout, exp;
        logic [3:0]  op;
        int          u0;
        u0 = $urandom(32'd2024);

        @(negedge tck); #1;
        repeat (3) step(1'b1, 1'b1);
        rst_n = 1'b1;
        mst = ST_RESET;
        // R1 R2 reset state
        chk("R2 reset instruction", {60'd0, instr_o}, 64'hF);
        chk("R9 reset oe", {62'd0, tdo_oe, tdo}, 64'd0);
        chk("R8 reset strobes", {60'd0, bsr_sel, bsr_capture, bsr_shift, bsr_update}, 64'd0);
        step(1'b0, 1'b0);

        // R3 capture pattern, R4 IDCODE, R6 id value
        ir_scan(4'b0010, cap);
        chk("R3 capture pattern", {60'd0, cap}, 64'h1);
        dr_scan(40, 64'hAB_1234_5678, -1, dout);
        exp = '0;
        for (int i = 0; i < 40; i++) exp[i] = exp_dr(4'b0010, 64'hAB_1234_5678, i);
        chk("R6 identification stream", dout, exp);

        // R7 R8 EXTEST
        ir_scan(4'b0000, cap);
        chk("R7 extest flags", {62'd0, bsr_sel, bsr_extest}, 64'h3);
        u0 = upd_cnt;
        dr_scan(12, 64'hA5F, -1, dout);
        exp = '0;
        for (int i = 0; i < 12; i++) exp[i] = exp_dr(4'b0000, 64'hA5F, i);
        chk("R7 boundary stream", dout, exp);
        chk("R8 one update strobe", 64'(upd_cnt - u0), 64'd1);
        chk("R8 external register content", {56'd0, ext_q}, 64'hA5);

        // R7 SAMPLE
        ir_scan(4'b0101, cap);
        chk("R7 sample flags", {62'd0, bsr_sel, bsr_extest}, 64'h2);

        // R4 R5 unused code becomes bypass, no boundary strobes
        ir_scan(4'b0110, cap);
        chk("R4 unused code decodes bypass", {60'd0, instr_o}, 64'hF);
        u0 = upd_cnt;
        dr_scan(10, 64'h2D3, -1, dout);
        exp = '0;
        for (int i = 0; i < 10; i++) exp[i] = exp_dr(4'hF, 64'h2D3, i);
        chk("R5 bypass delay", dout, exp);
        chk("R8 no strobe under bypass", 64'(upd_cnt - u0), 64'd0);

        // R10 pause in the middle of an identification scan
        ir_scan(4'b0010, cap);
        dr_scan(40, 64'h77_0F0F_3C3C, 13, dout);
        exp = '0;
        for (int i = 0; i < 40; i++) exp[i] = exp_dr(4'b0010, 64'h77_0F0F_3C3C, i);
        chk("R10 stream continues after pause", dout, exp);

        // Random instructions and data scans, random pause positions (R4 R5 R6 R7)
        for (int k = 0; k < 24; k++) begin
            op  = 4'($urandom);
            din = {$urandom, $urandom};
            ir_scan(op, cap);
            chk("R3 capture pattern random", {60'd0, cap}, 64'h1);
            chk("R4 decode random", {60'd0, instr_o}, {60'd0, decode(op)});
            dr_scan(40, din, int'($urandom % 45), dout);
            exp = '0;
            for (int i = 0; i < 40; i++) exp[i] = exp_dr(decode(op), din, i);
            chk("R5 R6 R7 random data scan", dout, exp);
        end

        // Random tms walk against the state model (R1 R9), then five ones (R2)
        ir_scan(4'b0010, cap);
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom), 1'($urandom));
            chk("R1 R9 output enable follows state",
                {63'd0, tdo_oe}, {63'd0, (mst == ST_SHF_DR || mst == ST_SHF_IR)});
            if (!tdo_oe) chk("R9 tdo low when off", {63'd0, tdo}, 64'd0);
            if (k % 50 == 49) begin
                for (int j = 0; j < 5; j++) step(1'b1, 1'b0);
                chk("R2 five ones reach reset", {60'd0, mst}, {60'd0, ST_RESET});
                chk("R2 bypass after five ones", {60'd0, instr_o}, 64'hF);
            end
        end

        // R2 from the middle of a data shift
        to_idle();
        ir_scan(4'b0010, cap);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1);
        for (int j = 0; j < 5; j++) step(1'b1, 1'b0);
        chk("R2 reset from shift", {61'd0, instr_o == 4'hF, tdo_oe, tdo}, 64'h4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule